// File: doc/BRIEF.md
# Interrupt Pin Delivery Engine

This block holds the per-pin state of a 24-input interrupt router. Each pin has a signed assertion count instead of a level wire. Interrupt sources raise, lower or pulse a pin through a one-per-cycle command port. A delivery message goes out only when a pin's count steps from zero to one. It also goes out when an end-of-interrupt (EOI) for the pin's vector releases a level-triggered pin whose count is still positive.

The routing entries come in as a flat vector from a neighbouring register file. The block only decodes them. Remote-IRR is kept here and driven back out so the register file can show it. Messages leave through one valid/ready port. When more than one pin is waiting, the lowest-numbered pin goes first. Message acceptance and prioritisation in the local controllers are left to the consumer.

Top module: `irq_pin_engine`

## Requirements
- R1: An assert command (`cmd_op` = 2'b00) increments the pin's count and a deassert (2'b01) decrements it. A delivery is attempted only on the assert that takes the count from 0 to 1.
- R2: A pulse command (2'b10) leaves the count unchanged. It attempts one delivery when the count was 0 and none otherwise.
- R3: When a deassert leaves the count below zero, or a pulse finds it below zero, `cnt_neg` is high for one cycle in the cycle after the command. The negative count is kept, and a later assert that reaches exactly 1 fires again.
- R4: A command whose pin number is 24 or more, or whose op is 2'b11, raises `cmd_err` for one cycle in the cycle after the command. It changes no count, no pending delivery and no remote-IRR. Its pin number is compared in full, never truncated.
- R5: An attempt on a pin whose entry mask bit (bit 16 = 1) is set when the attempt is made is dropped without a message.
- R6: When a pin whose entry has the trigger bit set (bit 15 = 1, level) is issued, its `remote_irr` bit goes high and stays high until cleared by R7.
- R7: An EOI clears remote-IRR on every pin whose remote-IRR is set and whose entry vector (bits 7:0) equals `eoi_vector`. Each such pin with a count above zero is attempted again, subject to R5. An EOI with no matching pin has no effect.
- R8: A message carries the pin number, vector = entry bits 7:0, delivery mode = bits 10:8, logical flag = bit 11 (1 = logical, 0 = physical), level flag = bit 15 and destination = bits 63:56. Other entry bits are ignored.
- R9: Counts are 8-bit signed and saturate at +127 and -128, with no wrap-around.
- R10: Pending pins are issued one at a time, the lowest pin number first whenever the output stage loads. A message with `dlv_valid` high and `dlv_ready` low holds all its fields unchanged.
- R11: After reset all counts are 0, nothing is pending, `remote_irr` is all zeros and `dlv_valid`, `cmd_err` and `cnt_neg` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Pin command present this cycle |
| cmd_op | input | 2 | 00 assert, 01 deassert, 10 pulse, 11 reserved |
| cmd_pin | input | 6 | Target pin number |
| eoi_valid | input | 1 | End-of-interrupt broadcast present |
| eoi_vector | input | 8 | Vector being acknowledged |
| route_tbl | input | 1536 | 24 routing entries of 64 bits, pin n at bits 64n+63:64n |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Consumer accepts the message |
| dlv_pin | output | 6 | Pin that raised the message |
| dlv_vector | output | 8 | Interrupt vector |
| dlv_mode | output | 3 | Delivery mode |
| dlv_logical | output | 1 | 1 logical, 0 physical destination |
| dlv_level | output | 1 | 1 level-triggered, 0 edge |
| dlv_dest | output | 8 | Destination field |
| remote_irr | output | 24 | Remote-IRR state per pin |
| cmd_err | output | 1 | Rejected command, one-cycle pulse |
| cnt_neg | output | 1 | Count went or stayed negative, one-cycle pulse |

## Verification
The embedded properties assume a routing table that is quasi-static: an entry may change between operations, but not while one of its pins is waiting to be issued. The remote-IRR and pending checks also assume commands and EOIs are ordered in time. The stimulus meets these assumptions by rewriting entries only while the block is idle. It also leaves each command or EOI enough idle cycles for every resulting message to drain before the next operation. Back-pressure is applied only in one directed ordering case, and `dlv_ready` is held high everywhere else.

// File: rtl/ipe_pkg.sv
package ipe_pkg;

   typedef enum logic [1:0] {
      OP_ASSERT   = 2'b00,
      OP_DEASSERT = 2'b01,
      OP_PULSE    = 2'b10,
      OP_RSVD     = 2'b11
   } pin_op_e;

   // routing entry geometry, decoded by the register file as well
   localparam int ENT_W    = 64;
   localparam int VEC_W    = 8;
   localparam int MODE_W   = 3;
   localparam int DEST_W   = 8;
   localparam int VEC_LO   = 0;
   localparam int MODE_LO  = 8;
   localparam int LOGIC_B  = 11;
   localparam int TRIG_B   = 15;
   localparam int MASK_B   = 16;
   localparam int DEST_LO  = ENT_W - DEST_W;

   typedef struct packed {
      logic [VEC_W-1:0]  vector;
      logic [MODE_W-1:0] mode;
      logic              logical;
      logic              level;
      logic              masked;
      logic [DEST_W-1:0] dest;
   } route_t;

   function automatic route_t decode_entry(input logic [ENT_W-1:0] e);
      route_t r;
      r.vector  = e[VEC_LO +: VEC_W];
      r.mode    = e[MODE_LO +: MODE_W];
      r.logical = e[LOGIC_B];
      r.level   = e[TRIG_B];
      r.masked  = e[MASK_B];
      r.dest    = e[DEST_LO +: DEST_W];
      return r;
   endfunction

endpackage

// File: rtl/ipe_pin_slot.sv
module ipe_pin_slot
   import ipe_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_hit,
   input  pin_op_e          cmd_op,
   input  route_t           ent,
   input  logic             eoi_valid,
   input  logic [VEC_W-1:0] eoi_vec,
   input  logic             take,
   output logic             pend,
   output logic             rirr,
   output logic             neg_evt
);

   localparam logic [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
   localparam logic [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt, cnt_nx;
   logic cmd_fire, eoi_hit, eoi_fire, fire, is_zero, is_pos;

   assign is_zero = (cnt == '0);
   assign is_pos  = !cnt[CNT_W-1] && !is_zero;

   always_comb begin
      cnt_nx   = cnt;
      cmd_fire = 1'b0;
      neg_evt  = 1'b0;
      if (cmd_hit) begin
         case (cmd_op)
            OP_ASSERT: begin
               if (cnt != CMAX) cnt_nx = cnt + ONE;
               cmd_fire = is_zero;
            end
            OP_DEASSERT: begin
               if (cnt != CMIN) cnt_nx = cnt - ONE;
               neg_evt = cnt_nx[CNT_W-1];
            end
            OP_PULSE: begin
               cmd_fire = is_zero;
               neg_evt  = cnt[CNT_W-1];
            end
            default: ;
         endcase
      end
   end

   assign eoi_hit  = eoi_valid && rirr && (ent.vector == eoi_vec);
   assign eoi_fire = eoi_hit && is_pos;
   assign fire     = (cmd_fire || eoi_fire) && !ent.masked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
         rirr <= 1'b0;
      end else begin
         cnt  <= cnt_nx;
         pend <= (pend && !take) || fire;
         rirr <= (rirr && !eoi_hit) || (take && ent.level);
      end
   end

   p_fire_on_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> ($past(cnt) == '0) || $past(eoi_valid));

   p_masked_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> !$past(ent.masked));

   p_sat_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CMAX) |=> (cnt != CMIN));

   p_sat_bottom_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CMIN) |=> (cnt != CMAX));

   p_rirr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rirr) |-> $past(take && ent.level));

   p_rirr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rirr) |-> $past(eoi_valid && (eoi_vec == ent.vector)));

endmodule

// File: rtl/ipe_lowest_pick.sv
module ipe_lowest_pick #(
   parameter int N     = 24,
   parameter int IDX_W = 6
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     gnt,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   always_comb begin
      gnt = '0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
            idx    = IDX_W'(i);
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/ipe_msg_stage.sv
module ipe_msg_stage
   import ipe_pkg::*;
#(
   parameter int PIN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any,
   input  logic [PIN_W-1:0] idx,
   input  route_t           sel,
   input  logic             ready,
   output logic             valid,
   output logic             load,
   output logic [PIN_W-1:0] pin,
   output route_t           msg
);

   assign load = any && (!valid || ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         pin   <= '0;
         msg   <= '0;
      end else if (load) begin
         valid <= 1'b1;
         pin   <= idx;
         msg   <= sel;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

   p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(pin) && $stable(msg)));

endmodule

// File: rtl/irq_pin_engine.sv
module irq_pin_engine
   import ipe_pkg::*;
#(
   parameter int NUM_PINS = 24,
   parameter int PIN_W    = 6,
   parameter int CNT_W    = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_valid,
   input  logic [1:0]                cmd_op,
   input  logic [PIN_W-1:0]          cmd_pin,
   input  logic                      eoi_valid,
   input  logic [VEC_W-1:0]          eoi_vector,
   input  logic [NUM_PINS*ENT_W-1:0] route_tbl,
   output logic                      dlv_valid,
   input  logic                      dlv_ready,
   output logic [PIN_W-1:0]          dlv_pin,
   output logic [VEC_W-1:0]          dlv_vector,
   output logic [MODE_W-1:0]         dlv_mode,
   output logic                      dlv_logical,
   output logic                      dlv_level,
   output logic [DEST_W-1:0]         dlv_dest,
   output logic [NUM_PINS-1:0]       remote_irr,
   output logic                      cmd_err,
   output logic                      cnt_neg
);

   localparam int PIN_SPAN = 1 << PIN_W;

   if (NUM_PINS < 1 || NUM_PINS > PIN_SPAN) begin : g_bad_pins
      $error("irq_pin_engine: NUM_PINS does not fit PIN_W");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("irq_pin_engine: CNT_W must be at least 2");
   end

   pin_op_e             op;
   logic                pin_ok, op_ok, cmd_ok;
   logic [NUM_PINS-1:0] pend, take, gnt, neg_evt;
   logic [PIN_W-1:0]    pick_idx;
   logic                pick_any, load;
   route_t              ent_d [NUM_PINS];
   route_t              sel, msg;

   assign op     = pin_op_e'(cmd_op);
   assign pin_ok = (32'(cmd_pin) < NUM_PINS);
   assign op_ok  = (op != OP_RSVD);
   assign cmd_ok = cmd_valid && pin_ok && op_ok;
   assign take   = load ? gnt : '0;

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      assign ent_d[g] = decode_entry(route_tbl[g*ENT_W +: ENT_W]);

      ipe_pin_slot #(.CNT_W(CNT_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .cmd_hit   (cmd_ok && (cmd_pin == PIN_W'(g))),
         .cmd_op    (op),
         .ent       (ent_d[g]),
         .eoi_valid (eoi_valid),
         .eoi_vec   (eoi_vector),
         .take      (take[g]),
         .pend      (pend[g]),
         .rirr      (remote_irr[g]),
         .neg_evt   (neg_evt[g])
      );
   end

   ipe_lowest_pick #(.N(NUM_PINS), .IDX_W(PIN_W)) u_pick (
      .req (pend),
      .gnt (gnt),
      .idx (pick_idx),
      .any (pick_any)
   );

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (gnt[i]) sel = sel | ent_d[i];
      end
   end

   ipe_msg_stage #(.PIN_W(PIN_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .any   (pick_any),
      .idx   (pick_idx),
      .sel   (sel),
      .ready (dlv_ready),
      .valid (dlv_valid),
      .load  (load),
      .pin   (dlv_pin),
      .msg   (msg)
   );

   assign dlv_vector  = msg.vector;
   assign dlv_mode    = msg.mode;
   assign dlv_logical = msg.logical;
   assign dlv_level   = msg.level;
   assign dlv_dest    = msg.dest;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_err <= 1'b0;
         cnt_neg <= 1'b0;
      end else begin
         cmd_err <= cmd_valid && !(pin_ok && op_ok);
         cnt_neg <= |neg_evt;
      end
   end

   p_single_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take));

   p_reject_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !pin_ok && !eoi_valid)
      |=> ($countones(pend) <= $past($countones(pend))));

   p_reject_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !op_ok) |=> cmd_err);

endmodule

// File: tb/tb_irq_pin_engine.sv
`timescale 1ns/1ps
module tb_irq_pin_engine;
   import ipe_pkg::*;

   localparam int NP = 24;
   localparam int PW = 6;
   localparam int MW = PW + 8 + 3 + 1 + 1 + 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n;
   logic              cmd_valid;
   logic [1:0]        cmd_op;
   logic [PW-1:0]     cmd_pin;
   logic              eoi_valid;
   logic [7:0]        eoi_vector;
   logic [NP*64-1:0]  route_tbl;
   logic              dlv_valid, dlv_ready;
   logic [PW-1:0]     dlv_pin;
   logic [7:0]        dlv_vector, dlv_dest;
   logic [2:0]        dlv_mode;
   logic              dlv_logical, dlv_level;
   logic [NP-1:0]     remote_irr;
   logic              cmd_err, cnt_neg;

   logic [63:0] ent [NP];
   for (genvar g = 0; g < NP; g++) begin : g_tbl
      assign route_tbl[g*64 +: 64] = ent[g];
   end

   irq_pin_engine dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_pin(cmd_pin), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .route_tbl(route_tbl), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
      .dlv_pin(dlv_pin), .dlv_vector(dlv_vector), .dlv_mode(dlv_mode),
      .dlv_logical(dlv_logical), .dlv_level(dlv_level), .dlv_dest(dlv_dest),
      .remote_irr(remote_irr), .cmd_err(cmd_err), .cnt_neg(cnt_neg)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   int            mcnt  [NP];
   bit            mrirr [NP];
   logic [MW-1:0] expq [64];
   logic [MW-1:0] actq [64];
   int            expn, actn;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [MW-1:0] msg_of(input int p);
      return {PW'(p), ent[p][7:0], ent[p][10:8], ent[p][11], ent[p][15], ent[p][63:56]};
   endfunction

   function automatic logic [NP-1:0] rirr_vec();
      logic [NP-1:0] v;
      for (int p = 0; p < NP; p++) v[p] = mrirr[p];
      return v;
   endfunction

   task automatic model_deliver(input int p);
      if (!ent[p][16]) begin
         if (expn < 64) expq[expn] = msg_of(p);
         expn++;
         if (ent[p][15]) mrirr[p] = 1'b1;
      end
   endtask

   task automatic model_cmd(input int p, input int op, output bit e_err, output bit e_neg);
      int old;
      e_err = 1'b0;
      e_neg = 1'b0;
      if (p >= NP || op == 3) begin
         e_err = 1'b1;
         return;
      end
      old = mcnt[p];
      case (op)
         0: begin
            if (old < 127) mcnt[p] = old + 1;
            if (old == 0) model_deliver(p);
         end
         1: begin
            if (old > -128) mcnt[p] = old - 1;
            e_neg = (mcnt[p] < 0);
         end
         default: begin
            if (old == 0) model_deliver(p);
            e_neg = (old < 0);
         end
      endcase
   endtask

   task automatic model_eoi(input logic [7:0] v);
      for (int p = 0; p < NP; p++) begin
         if (mrirr[p] && ent[p][7:0] == v) begin
            mrirr[p] = 1'b0;
            if (mcnt[p] > 0) model_deliver(p);
         end
      end
   endtask

   task automatic collect(input int n);
      actn = 0;
      for (int k = 0; k < n; k++) begin
         if (dlv_valid && dlv_ready && actn < 64) begin
            actq[actn] = {dlv_pin, dlv_vector, dlv_mode, dlv_logical, dlv_level, dlv_dest};
            actn++;
         end
         @(negedge clk);
      end
   endtask

   task automatic compare(input string req);
      check(actn == expn, req, "message count", 64'(actn), 64'(expn));
      for (int i = 0; i < actn && i < expn; i++)
         check(actq[i] == expq[i], req, "message content", 64'(actq[i]), 64'(expq[i]));
      check(remote_irr == rirr_vec(), req, "remote_irr", 64'(remote_irr), 64'(rirr_vec()));
   endtask

   task automatic drive_cmd(input int p, input int op);
      cmd_valid = 1'b1;
      cmd_pin   = PW'(p);
      cmd_op    = 2'(op);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic do_cmd(input int p, input int op, input string req, input int win = 6);
      bit e_err, e_neg;
      expn = 0;
      model_cmd(p, op, e_err, e_neg);
      drive_cmd(p, op);
      check(cmd_err == e_err, req, "cmd_err", 64'(cmd_err), 64'(e_err));
      check(cnt_neg == e_neg, req, "cnt_neg", 64'(cnt_neg), 64'(e_neg));
      collect(win);
      compare(req);
   endtask

   task automatic do_eoi(input logic [7:0] v, input string req);
      expn = 0;
      model_eoi(v);
      eoi_valid  = 1'b1;
      eoi_vector = v;
      @(negedge clk);
      eoi_valid = 1'b0;
      collect(30);
      compare(req);
   endtask

   task automatic set_ent(input int p, input logic [7:0] vec, input logic [2:0] mode,
                          input bit logical, input bit level, input bit mask,
                          input logic [7:0] dest);
      logic [63:0] e;
      e = '0;
      e[7:0]   = vec;
      e[10:8]  = mode;
      e[11]    = logical;
      e[15]    = level;
      e[16]    = mask;
      e[63:56] = dest;
      e[13]    = 1'b1;          // ignored bit, must not leak into messages (R8)
      ent[p]   = e;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit e_err, e_neg;
      void'($urandom(32'h1A2B3C));
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_pin = '0;
      eoi_valid = 1'b0; eoi_vector = '0; dlv_ready = 1'b1;
      for (int p = 0; p < NP; p++) begin
         ent[p]   = 64'h0000_0000_0001_0000;
         mcnt[p]  = 0;
         mrirr[p] = 1'b0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      check(dlv_valid == 1'b0, "R11", "dlv_valid", 64'(dlv_valid), 0);
      check(remote_irr == '0, "R11", "remote_irr", 64'(remote_irr), 0);
      check(cmd_err == 1'b0 && cnt_neg == 1'b0, "R11", "error flags", 64'({cmd_err, cnt_neg}), 0);

      // R1 count and 0->1 firing
      set_ent(1, 8'h21, 3'd0, 1'b0, 1'b0, 1'b0, 8'h03);
      do_cmd(1, 0, "R1");
      do_cmd(1, 0, "R1");
      do_cmd(1, 1, "R1");
      do_cmd(1, 1, "R1");
      do_cmd(1, 0, "R1");
      do_cmd(1, 1, "R1");
      // R3 negative count flagged and kept
      do_cmd(1, 1, "R3");
      do_cmd(1, 0, "R3");
      do_cmd(1, 0, "R3");
      do_cmd(1, 1, "R3");
      // R2 pulse
      do_cmd(1, 2, "R2");
      do_cmd(1, 2, "R2");
      do_cmd(1, 0, "R2");
      do_cmd(1, 2, "R2");
      do_cmd(1, 1, "R2");
      do_cmd(1, 1, "R3");
      do_cmd(1, 2, "R3");
      do_cmd(1, 0, "R3");

      // R4 rejected commands; pin 37 aliases pin 5 if truncated
      set_ent(5, 8'h25, 3'd1, 1'b0, 1'b0, 1'b0, 8'h05);
      do_cmd(37, 0, "R4");
      do_cmd(24, 0, "R4");
      do_cmd(5, 3, "R4");
      do_cmd(5, 0, "R4");
      do_cmd(5, 1, "R4");

      // R5 masked
      set_ent(6, 8'h26, 3'd0, 1'b0, 1'b0, 1'b1, 8'h06);
      do_cmd(6, 0, "R5");
      do_cmd(6, 1, "R5");

      // R8 message fields
      set_ent(2, 8'h33, 3'd5, 1'b1, 1'b0, 1'b0, 8'hA7);
      do_cmd(2, 0, "R8");
      do_cmd(2, 1, "R8");

      // R6 / R7 level pins, EOI by vector, ascending re-delivery
      set_ent(8,  8'h50, 3'd0, 1'b0, 1'b1, 1'b0, 8'h08);
      set_ent(10, 8'h50, 3'd2, 1'b1, 1'b1, 1'b0, 8'h0A);
      do_cmd(10, 0, "R6");
      do_cmd(8, 0, "R6");
      do_eoi(8'h51, "R7");
      do_eoi(8'h50, "R7");
      do_cmd(8, 1, "R7");
      do_eoi(8'h50, "R7");
      do_cmd(10, 1, "R7");
      do_eoi(8'h50, "R7");
      set_ent(7, 8'h57, 3'd0, 1'b0, 1'b1, 1'b0, 8'h07);
      do_cmd(7, 0, "R6");
      set_ent(7, 8'h57, 3'd0, 1'b0, 1'b1, 1'b1, 8'h07);
      do_eoi(8'h57, "R5");
      set_ent(7, 8'h57, 3'd0, 1'b0, 1'b1, 1'b0, 8'h07);
      do_cmd(7, 1, "R7");

      // R10 ordering under back-pressure
      set_ent(3,  8'h13, 3'd0, 1'b0, 1'b0, 1'b0, 8'h33);
      set_ent(9,  8'h19, 3'd0, 1'b0, 1'b0, 1'b0, 8'h99);
      set_ent(15, 8'h1F, 3'd0, 1'b0, 1'b0, 1'b0, 8'hFF);
      dlv_ready = 1'b0;
      expn = 0;
      model_cmd(9, 0, e_err, e_neg);
      drive_cmd(9, 0);
      model_cmd(3, 0, e_err, e_neg);
      drive_cmd(3, 0);
      model_cmd(15, 0, e_err, e_neg);
      drive_cmd(15, 0);
      repeat (4) @(negedge clk);
      check(dlv_valid == 1'b1 && dlv_pin == PW'(9), "R10", "stalled head",
            64'({dlv_valid, dlv_pin}), 64'({1'b1, PW'(9)}));
      dlv_ready = 1'b1;
      collect(10);
      compare("R10");
      do_cmd(9, 1, "R10");
      do_cmd(3, 1, "R10");
      do_cmd(15, 1, "R10");

      // R9 saturation both ways
      set_ent(11, 8'h2B, 3'd0, 1'b0, 1'b0, 1'b0, 8'h0B);
      for (int k = 0; k < 130; k++) do_cmd(11, 0, "R9", 4);
      for (int k = 0; k < 127; k++) do_cmd(11, 1, "R9", 4);
      do_cmd(11, 0, "R9");
      do_cmd(11, 1, "R9");
      for (int k = 0; k < 130; k++) do_cmd(11, 1, "R9", 3);
      for (int k = 0; k < 128; k++) do_cmd(11, 0, "R9", 3);
      do_cmd(11, 0, "R9");
      do_cmd(11, 1, "R9");

      // constrained random mix
      for (int p = 0; p < NP; p++)
         set_ent(p, 8'h40 + 8'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 3) == 0), 8'($urandom_range(0, 255)));
      for (int n = 0; n < 400; n++) begin
         int r;
         r = $urandom_range(0, 9);
         if (r < 7)
            do_cmd($urandom_range(0, 29), $urandom_range(0, 3), "R1");
         else if (r < 9)
            do_eoi(8'h40 + 8'($urandom_range(0, 4)), "R7");
         else
            set_ent($urandom_range(0, NP - 1), 8'h40 + 8'($urandom_range(0, 3)),
                    3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                    8'($urandom_range(0, 255)));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule